// File: doc/BRIEF.md
# Sequential binary32 Square Root Unit

This unit takes the square root of one IEEE 754 binary32 operand over many clock cycles. The caller presents the operand with a one-cycle load strobe while the unit is idle. The unit then raises `busy` and keeps it high for a fixed number of cycles. When `busy` falls, the root word and a three-bit status are valid. They stay valid until the next operation completes, and a new operand may be loaded in the same cycle that `busy` is seen low.

Internally the operand is classified and normalized first. Subnormal inputs are shifted until the hidden one appears. If the unbiased exponent is odd, the significand is doubled, and the exponent is then halved. The significand root comes from a restoring digit recurrence, which is a division-like shift and subtract loop over a 50-bit radicand. The root is then rounded to nearest, ties to even. The `FAST_CORE` parameter picks the engine. With 0, a lean engine resolves one root bit per cycle and the whole operation takes 894 cycles. With 1, five cascaded trial stages resolve five root bits per cycle and the operation takes 257 cycles, at the cost of more area. Special operands bypass the arithmetic result but still take the full latency.

Top module: `fsq32_seq`

## Requirements
- R1: When `load` is high at a rising edge while `busy` is low, the unit captures `arg_in` (sign bit 31, biased exponent bits 30:23, fraction bits 22:0), and `busy` is high after that edge. Later changes on `arg_in` do not affect that operation.
- R2: After a capture, `busy` stays high for exactly 894 cycles with `FAST_CORE`=0, or exactly 257 cycles with `FAST_CORE`=1. It then falls at the same edge that updates `root` and `status`.
- R3: For a positive normal operand, `root` is the binary32 square root rounded to nearest, ties to even, and `status` is 3'b000.
- R4: A positive subnormal operand is normalized before the root is taken, and it yields the correctly rounded normal root with `status` 3'b000.
- R5: A NaN operand, or any negative operand other than -0 (including -inf and negative subnormals), returns the quiet NaN 32'h7FC00000 with `status` 3'b100 (bit 2 = NaN).
- R6: An operand of +inf returns 32'h7F800000 with `status` 3'b010 (bit 1 = infinity).
- R7: An operand of +0 or -0 returns the same signed zero with `status` 3'b000. Bit 0 of `status` marks a subnormal result, and at most one `status` bit is ever set.
- R8: `root` and `status` do not change while `busy` is high, and they keep the last result while the unit is idle.
- R9: A `load` pulse while `busy` is high is ignored: the running operation finishes at its normal time with the root of the original operand.
- R10: While `rst_n` is low at a rising edge, `busy`, `root` and `status` are cleared to zero, and a `load` during reset starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| arg_in | input | 32 | binary32 operand |
| load | input | 1 | Operand capture strobe, active high |
| root | output | 32 | binary32 result, valid while busy is low |
| status | output | 3 | bit 2 NaN, bit 1 infinity, bit 0 subnormal result |
| busy | output | 1 | High while an operation is in progress |

## Verification
The embedded assertions assume three things about the inputs. First, `load` is a synchronous strobe. Second, `arg_in` carries known values whenever `load` is high. Third, reset is held for at least one edge before the first operation. The stimulus keeps within these by driving every input on the falling edge and pulsing `load` for one cycle. The only other `load` pulse is the one deliberately placed mid-operation for R9. Operands come from a deterministic sweep: exponent values at and around the subnormal, unity and overflow boundaries, crossed with fraction patterns, plus every special class. Both engine variants run in parallel on the same operand, so results and latencies are compared against a root computed by integer bisection in the bench.

// File: rtl/fsq_pkg.sv
// Shared widths and types for the sequential binary32 square-root unit.
// Assumes binary32 layout: sign, 8-bit biased exponent, 23-bit fraction.
package fsq_pkg;
    localparam int WORD   = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int MANT_W = FRAC_W + 1;     // significand with hidden bit
    localparam int SIG_W  = MANT_W + 1;     // significand after odd-exponent doubling
    localparam int ROOT_W = MANT_W + 1;     // root bits: 24 kept plus one round bit
    localparam int DIG_W  = 2 * ROOT_W;     // radicand bits consumed by the recurrence
    localparam int REM_W  = ROOT_W + 3;     // partial remainder width
    localparam int LZ_W   = $clog2(FRAC_W + 1);
    localparam int BEXP_W = EXP_W + 1;      // twice-biased exponent workspace

    typedef enum logic [1:0] {
        K_FINITE = 2'd0,
        K_ZERO   = 2'd1,
        K_INF    = 2'd2,
        K_NAN    = 2'd3
    } kind_e;

    typedef struct packed {
        logic              sgn;
        kind_e             kind;
        logic [EXP_W-1:0]  rexp;
        logic [SIG_W-1:0]  sig;
    } opnd_t;
endpackage

// File: rtl/fsq_unpack.sv
// Operand classifier and normalizer.
// Sorts the operand into finite / zero / infinity / NaN-producing classes,
// left-justifies a subnormal fraction, doubles the significand when the
// unbiased exponent is odd and produces the biased exponent of the root.
// Purely combinational; assumes a binary32 input word.
module fsq_unpack
    import fsq_pkg::*;
(
    input  logic [WORD-1:0] arg,
    output opnd_t           opnd
);
    logic              sgn;
    logic [EXP_W-1:0]  efld;
    logic [FRAC_W-1:0] ffld;
    logic [LZ_W-1:0]   lz;
    logic              found;
    logic [MANT_W-1:0] mant;
    logic [BEXP_W-1:0] twice;   // unbiased exponent + 254, always positive
    logic              odd;

    assign {sgn, efld, ffld} = arg;

    // Leading-zero count of the fraction field, used only for subnormals.
    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            if (!found && ffld[i]) begin
                lz    = LZ_W'(FRAC_W - 1 - i);
                found = 1'b1;
            end
        end
    end

    // Normalized significand and exponent-plus-254 for normal or subnormal input.
    always_comb begin
        if (efld == '0) begin
            mant  = {1'b0, ffld} << (lz + LZ_W'(1));
            twice = BEXP_W'(127) - BEXP_W'(lz);
        end else begin
            mant  = {1'b1, ffld};
            twice = BEXP_W'(efld) + BEXP_W'(127);
        end
    end

    // Parity fix-up, exponent halving and class selection.
    always_comb begin
        odd       = twice[0];
        opnd.sgn  = sgn;
        opnd.sig  = odd ? {mant, 1'b0} : {1'b0, mant};
        opnd.rexp = twice[BEXP_W-1:1];
        if (efld == '1 && ffld != '0)
            opnd.kind = K_NAN;
        else if (efld == '0 && ffld == '0)
            opnd.kind = K_ZERO;
        else if (sgn)
            opnd.kind = K_NAN;
        else if (efld == '1)
            opnd.kind = K_INF;
        else
            opnd.kind = K_FINITE;
    end
endmodule

// File: rtl/fsq_stage.sv
// One restoring square-root digit step.
// Appends the next two radicand bits to the partial remainder, tries to
// subtract (4*q + 1), and shifts the resulting root bit into q.
// Assumes the incoming remainder never exceeds 2*q.
module fsq_stage
    import fsq_pkg::*;
(
    input  logic [REM_W-1:0]  rem_i,
    input  logic [ROOT_W-1:0] q_i,
    input  logic [1:0]        pair,
    output logic [REM_W-1:0]  rem_o,
    output logic [ROOT_W-1:0] q_o
);
    logic [REM_W-1:0] rem_sh;
    logic [REM_W-1:0] trial;
    logic             fits;

    // Trial subtraction and remainder restore.
    always_comb begin
        rem_sh = {rem_i[REM_W-3:0], pair};
        trial  = REM_W'({q_i, 2'b01});
        fits   = (rem_sh >= trial);
        rem_o  = fits ? (rem_sh - trial) : rem_sh;
        q_o    = {q_i[ROOT_W-2:0], fits};
    end
endmodule

// File: rtl/fsq_recur.sv
// Iterative integer square-root engine.
// Resolves STEP root bits per clock through a generated chain of digit
// stages. STEP must divide ROOT_W (1 and 5 are used). 'start' loads a new
// radicand; 'done' is high once all root bits are resolved.
module fsq_recur
    import fsq_pkg::*;
#(
    parameter int STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIG_W-1:0]  radicand,
    output logic [ROOT_W-1:0] q_out,
    output logic              rem_nz,
    output logic              done
);
    localparam int NSTEPS = ROOT_W / STEP;
    localparam int CNT_W  = $clog2(NSTEPS + 1);

    logic [DIG_W-1:0]  dig_q;
    logic [REM_W-1:0]  rem_q;
    logic [ROOT_W-1:0] q_q;
    logic [CNT_W-1:0]  left_q;

    logic [REM_W-1:0]  rem_w [STEP+1];
    logic [ROOT_W-1:0] q_w   [STEP+1];

    assign rem_w[0] = rem_q;
    assign q_w[0]   = q_q;

    for (genvar g = 0; g < STEP; g++) begin : g_stage
        fsq_stage u_stage (
            .rem_i (rem_w[g]),
            .q_i   (q_w[g]),
            .pair  (dig_q[DIG_W-1-2*g -: 2]),
            .rem_o (rem_w[g+1]),
            .q_o   (q_w[g+1])
        );
    end

    // Load a radicand, then advance STEP digits per cycle until exhausted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dig_q  <= '0;
            rem_q  <= '0;
            q_q    <= '0;
            left_q <= '0;
        end else if (start) begin
            dig_q  <= radicand;
            rem_q  <= '0;
            q_q    <= '0;
            left_q <= CNT_W'(NSTEPS);
        end else if (left_q != '0) begin
            dig_q  <= dig_q << (2 * STEP);
            rem_q  <= rem_w[STEP];
            q_q    <= q_w[STEP];
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign q_out  = q_q;
    assign rem_nz = (rem_q != '0);
    assign done   = (left_q == '0);

    // Restoring-root invariant: remainder never exceeds twice the partial root.
    p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q <= REM_W'({q_q, 1'b0}));
endmodule

// File: rtl/fsq_pack.sv
// Result assembler.
// Rounds the 25-bit root to nearest-even using the round bit and the
// remainder, folds a rounding carry into the exponent, and substitutes
// the fixed words for zero, infinity and NaN classes. Combinational.
module fsq_pack
    import fsq_pkg::*;
(
    input  kind_e             kind,
    input  logic              sgn,
    input  logic [EXP_W-1:0]  rexp,
    input  logic [ROOT_W-1:0] q_in,
    input  logic              rem_nz,
    output logic [WORD-1:0]   word,
    output logic [2:0]        stat
);
    logic              bump;
    logic [MANT_W:0]   rounded;
    logic              carry;
    logic [EXP_W-1:0]  exp_out;
    logic [FRAC_W-1:0] frac_out;

    // Nearest-even increment and carry handling.
    always_comb begin
        bump     = q_in[0] & (rem_nz | q_in[1]);
        rounded  = {1'b0, q_in[ROOT_W-1:1]} + (MANT_W+1)'(bump);
        carry    = rounded[MANT_W];
        exp_out  = rexp + EXP_W'(carry);
        frac_out = carry ? '0 : rounded[FRAC_W-1:0];
    end

    // Class-dependent output word and flags.
    always_comb begin
        unique case (kind)
            K_ZERO: begin
                word = {sgn, {(WORD-1){1'b0}}};
                stat = 3'b000;
            end
            K_INF: begin
                word = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                stat = 3'b010;
            end
            K_NAN: begin
                word = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
                stat = 3'b100;
            end
            default: begin
                word = {1'b0, exp_out, frac_out};
                stat = {2'b00, ~carry & ~rounded[FRAC_W]};
            end
        endcase
    end
endmodule

// File: rtl/fsq32_seq.sv
// Sequential binary32 square root with load/busy handshake.
// Captures an operand on 'load' while idle, runs the digit-recurrence
// engine, and releases the rounded result after a fixed LATENCY cycles.
// FAST_CORE = 0: one root bit per cycle, 894-cycle latency.
// FAST_CORE = 1: five root bits per cycle, 257-cycle latency.
// Assumes 'load' is synchronous and 'arg_in' is known while it is high.
module fsq32_seq
    import fsq_pkg::*;
#(
    parameter bit FAST_CORE = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WORD-1:0] arg_in,
    input  logic            load,
    output logic [WORD-1:0] root,
    output logic [2:0]      status,
    output logic            busy
);
    localparam int STEP    = FAST_CORE ? 5 : 1;
    localparam int LATENCY = FAST_CORE ? 257 : 894;
    localparam int LAT_W   = $clog2(LATENCY);

    opnd_t             opnd_in;
    logic              take;
    logic              finish;
    logic              busy_q;
    logic [LAT_W-1:0]  cnt_q;
    kind_e             kind_q;
    logic              sgn_q;
    logic [EXP_W-1:0]  rexp_q;
    logic [WORD-1:0]   root_q;
    logic [2:0]        status_q;
    logic [ROOT_W-1:0] rec_q;
    logic              rec_rem_nz;
    logic              rec_done;
    logic [WORD-1:0]   word_nx;
    logic [2:0]        stat_nx;

    fsq_unpack u_unpack (
        .arg  (arg_in),
        .opnd (opnd_in)
    );

    assign take   = load & ~busy_q;
    assign finish = busy_q && (cnt_q == LAT_W'(LATENCY - 1));

    fsq_recur #(.STEP(STEP)) u_recur (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (take),
        .radicand ({opnd_in.sig, {(DIG_W-SIG_W){1'b0}}}),
        .q_out    (rec_q),
        .rem_nz   (rec_rem_nz),
        .done     (rec_done)
    );

    fsq_pack u_pack (
        .kind   (kind_q),
        .sgn    (sgn_q),
        .rexp   (rexp_q),
        .q_in   (rec_q),
        .rem_nz (rec_rem_nz),
        .word   (word_nx),
        .stat   (stat_nx)
    );

    // Handshake, fixed-latency count and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            kind_q   <= K_ZERO;
            sgn_q    <= 1'b0;
            rexp_q   <= '0;
            root_q   <= '0;
            status_q <= '0;
        end else if (take) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            kind_q <= opnd_in.kind;
            sgn_q  <= opnd_in.sgn;
            rexp_q <= opnd_in.rexp;
        end else if (finish) begin
            busy_q   <= 1'b0;
            root_q   <= word_nx;
            status_q <= stat_nx;
        end else if (busy_q) begin
            cnt_q <= cnt_q + LAT_W'(1);
        end
    end

    assign root   = root_q;
    assign status = status_q;
    assign busy   = busy_q;

    // A capture always makes the unit busy on the following cycle.
    p_take_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> busy);

    // The latency counter stays inside its window.
    p_cnt_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < LAT_W'(LATENCY)));

    // The engine has resolved every root bit before the result is released.
    p_engine_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> rec_done);

    // A NaN flag comes with a quiet NaN word.
    p_nan_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> (root[30:23] == 8'hFF && root[22]));

    // An infinity flag comes with the +inf word.
    p_inf_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> (root == 32'h7F80_0000));

    // Status flags are mutually exclusive.
    p_status_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status));

    // Outputs hold while an operation runs.
    p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(root) && $stable(status)));

    // A load while busy leaves the captured operand untouched.
    p_ignore_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && busy_q) |=> ($stable(kind_q) && $stable(rexp_q) && $stable(sgn_q)));
endmodule

// File: tb/fsq32_seq_test.sv
`timescale 1ns/1ps
module fsq32_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [31:0] arg = 32'h0;
    logic [31:0] root_s, root_f;
    logic [2:0]  st_s, st_f;
    logic        busy_s, busy_f;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fsq32_seq #(.FAST_CORE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .arg_in(arg), .load(load),
        .root(root_s), .status(st_s), .busy(busy_s));

    fsq32_seq #(.FAST_CORE(1'b1)) uut_hr (
        .clk(clk), .rst_n(rst_n), .arg_in(arg), .load(load),
        .root(root_f), .status(st_f), .busy(busy_f));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference root: integer bisection on the scaled significand.
    function automatic void model(input logic [31:0] a, output logic [31:0] r, output logic [2:0] st);
        int     e_f = int'(a[30:23]);
        longint f   = longint'(a[22:0]);
        longint m, d, lo, hi, mid, fr;
        int     t, bexp;
        if ((e_f == 255 && f != 0) || (a[31] && (e_f != 0 || f != 0))) begin
            r = 32'h7FC0_0000; st = 3'b100; return;
        end
        if (e_f == 0 && f == 0) begin
            r = {a[31], 31'b0}; st = 3'b000; return;
        end
        if (e_f == 255) begin
            r = 32'h7F80_0000; st = 3'b010; return;
        end
        if (e_f == 0) begin
            m = f; t = -149;
            while (m < (64'sd1 << 23)) begin m = m * 2; t--; end
        end else begin
            m = f + (64'sd1 << 23); t = e_f - 150;
        end
        if ((t & 1) == 0) begin m = m * 2; t--; end
        d = m << 25;
        lo = 0; hi = 64'sd1 << 26;
        while (hi - lo > 1) begin
            mid = (lo + hi) / 2;
            if (mid * mid <= d) lo = mid; else hi = mid;
        end
        fr = lo >> 1;
        if ((lo & 1) != 0 && ((d != lo * lo) || ((fr & 1) != 0))) fr++;
        bexp = (t + 23) / 2 + 127;
        if (fr == (64'sd1 << 24)) begin fr = 64'sd1 << 23; bexp++; end
        r = {1'b0, 8'(bexp), 23'(fr)};
        st = 3'b000;
    endfunction

    // One operation on both engines; inputs change only at falling edges.
    task automatic run_op(input logic [31:0] a, input string tag);
        logic [31:0] er;
        logic [2:0]  es;
        logic [31:0] prev_s = root_s;
        logic [31:0] prev_f = root_f;
        int lat_s = 0;
        int lat_f = 0;
        int iter = 0;
        bit moved = 1'b0;
        model(a, er, es);
        arg  = a;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        arg  = 32'h4B00_0000;
        while ((busy_s || busy_f) && iter < 1200) begin
            if (busy_s) begin lat_s++; if (root_s !== prev_s) moved = 1'b1; end
            if (busy_f) begin lat_f++; if (root_f !== prev_f) moved = 1'b1; end
            load = (iter == 100);
            iter++;
            @(negedge clk);
        end
        load = 1'b0;
        chk(lat_s == 894, {"R2 radix-2 latency ", tag}, lat_s, 894);
        chk(lat_f == 257, {"R2 high-radix latency ", tag}, lat_f, 257);
        chk(root_s === er, {tag, " radix-2 root (R9 mid-run load ignored)"}, root_s, er);
        chk(root_f === er, {tag, " high-radix root (R9 mid-run load ignored)"}, root_f, er);
        chk(st_s === es, {tag, " radix-2 status"}, 32'(st_s), 32'(es));
        chk(st_f === es, {tag, " high-radix status"}, 32'(st_f), 32'(es));
        chk(!moved, {"R8 output moved while busy ", tag}, 32'(moved), 0);
    endtask

    initial begin
        int ev[12] = '{0, 1, 2, 3, 64, 126, 127, 128, 129, 200, 253, 254};
        logic [22:0] fv[8] = '{23'h000000, 23'h000001, 23'h400000, 23'h7FFFFF,
                               23'h2AAAAA, 23'h155555, 23'h123457, 23'h7FFFFE};
        // R10: a load during reset must start nothing
        arg  = 32'h4080_0000;
        load = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        load  = 1'b0;
        chk(busy_s === 1'b0 && busy_f === 1'b0, "R10 busy after reset", {30'b0, busy_s, busy_f}, 0);
        chk(root_s === 32'h0 && root_f === 32'h0, "R10 root after reset", root_s | root_f, 0);
        chk(st_s === 3'b0 && st_f === 3'b0, "R10 status after reset", 32'(st_s | st_f), 0);
        @(negedge clk);
        chk(busy_s === 1'b0, "R10 no start from reset-time load", 32'(busy_s), 0);

        // R3 anchor values with known roots
        run_op(32'h4080_0000, "R3 sqrt(4)");
        chk(root_s === 32'h4000_0000, "R3 sqrt(4) literal", root_s, 32'h4000_0000);
        run_op(32'h4110_0000, "R3 sqrt(9)");
        chk(root_s === 32'h4040_0000, "R3 sqrt(9) literal", root_s, 32'h4040_0000);
        run_op(32'h3E80_0000, "R3 sqrt(0.25)");
        chk(root_f === 32'h3F00_0000, "R3 sqrt(0.25) literal", root_f, 32'h3F00_0000);

        // Special classes
        run_op(32'h8000_0000, "R7 minus zero");
        run_op(32'h7F80_0000, "R6 plus inf");
        run_op(32'hFF80_0000, "R5 minus inf");
        run_op(32'h7FC0_0000, "R5 quiet NaN in");
        run_op(32'h7F80_0001, "R5 signalling NaN in");
        run_op(32'hFFFF_FFFF, "R5 negative NaN in");
        run_op(32'hBF80_0000, "R5 minus one");
        run_op(32'h8000_0001, "R5 negative subnormal");

        // Sweep exponent boundaries against fraction patterns
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [31:0] a = {1'b0, 8'(ev[i]), fv[j]};
                if (ev[i] == 0 && fv[j] == 0)      run_op(a, "R7 plus zero");
                else if (ev[i] == 0)               run_op(a, "R4 subnormal");
                else                               run_op(a, "R3 normal");
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule